// File: doc/BRIEF.md
# Flash Control Key-Lock Unit

This block guards the control register of a flash controller against stray writes. It holds two independent locks: a main lock over the control register, and an option lock over the option-byte configuration. Software opens each lock by writing two fixed 32-bit keys, in order and with no other register access between them, to that lock's own key register. The option lock only accepts keys once the main lock is open. Either lock can be closed again by writing its lock bit in the control register.

Other controller logic uses the lock outputs to gate its own writes. The general control field is writable only while the main lock is open. A reload request bit asks for an option-byte reload. The block answers that request with a reset pulse of fixed length, but only while both locks are open. A wrong key, a key written out of order, or a key written to a lock that is already open puts that lock into a sticky fault state. In that state the lock cannot be opened again until reset, and every later key write to it answers with a bus error.

Top module: `flash_keylock`

## Requirements
- R1: After reset both locks are closed, the general control field and the reload pulse are zero, and a read of the control register (word 0) returns 0xC000_0000 with no error.
- R2: The main lock opens when 0x45670123 and then 0xCDEF89AB are written to the main key register (word 1). Each of these writes answers without error, and the lock output clears on the clock edge that takes the second key.
- R3: With the main lock open, writing 0x08192A3B and then 0x4C5D6E7F to the option key register (word 2) opens the option lock. The option lock is never open while the main lock is closed.
- R4: A key value other than the one expected, or a key written while its lock is already open, answers with a bus error and sets a sticky fault for that lock. Until reset, every later key write to that lock answers with a bus error and the lock stays closed.
- R5: An option-key write while the main lock is closed answers with a bus error and has no effect. In particular it does not fault the option lock.
- R6: Any other register access between the first and second key cancels the half-done sequence. The second key that follows is then out of order and is handled under R4.
- R7: While the main lock is closed, writes to the control register change nothing except to set lock bits, and answer without error. Reads always answer without error.
- R8: Writing 1 to control bit 31 closes both locks. Writing 1 to bit 30 closes only the option lock. Control bit 31 reads as the main lock state and bit 30 reads as the option lock state, where 1 means closed.
- R9: Writing 1 to control bit 27 while both locks are open drives the reload reset output high for RELOAD_LEN cycles, starting on the next cycle. Otherwise the bit is ignored. It always reads as 0.
- R10: A control write that sets bit 31 or bit 30 only closes locks. Any reload request and any general-field value in that same write are discarded.
- R11: An access to a word other than 0, 1 or 2 answers with a bus error and read data 0. Reads of the key registers return 0 with no error.
- R12: While the main lock is open and no lock bit is set, a control write loads bits [CTRL_W-1:0] into the general control field. The field appears on the control output and reads back in the same bits.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous reset, active low |
| req_valid | input | 1 | Register access request in this cycle |
| req_write | input | 1 | 1 for a write, 0 for a read |
| req_addr | input | ADDR_W | Word index of the register |
| req_wdata | input | 32 | Write data |
| rsp_valid | output | 1 | Response for the request of the previous cycle |
| rsp_err | output | 1 | Bus error for that request |
| rsp_rdata | output | 32 | Read data for that request |
| main_locked | output | 1 | Main lock closed |
| opt_locked | output | 1 | Option lock closed |
| ctrl_bits | output | CTRL_W | General control field |
| reload_rst | output | 1 | Option-reload reset pulse |

## Verification
Closing a lock and requesting a reload can fall into one control write, since both are bits of the same word. The bench sends a write with bits 30 and 27 set together while both locks are open, plus a new general-field value. It then watches the reset output for several cycles, and reads the lock outputs and the general field. Only the option lock may close; no pulse may appear and the field must keep its old value. The same holds for a second collision case: a lock-bit write that arrives while the main key sequence is only half done must cancel that sequence, so the key that follows is judged as out of order.

// File: rtl/flash_keylock_pkg.sv
// Shared constants for the flash control key-lock unit.
// Assumes a 32-bit register port with word-indexed addresses.
package flash_keylock_pkg;

    localparam int unsigned KL_ADDR_CTRL = 0;
    localparam int unsigned KL_ADDR_MKEY = 1;
    localparam int unsigned KL_ADDR_OKEY = 2;

    localparam int unsigned KL_BIT_MLOCK  = 31;
    localparam int unsigned KL_BIT_OLOCK  = 30;
    localparam int unsigned KL_BIT_RELOAD = 27;

    localparam int unsigned KL_DOMAINS = 2;  // 0: main, 1: option

    localparam logic [31:0] KL_KEY_FIRST  [KL_DOMAINS] = '{32'h4567_0123, 32'h0819_2A3B};
    localparam logic [31:0] KL_KEY_SECOND [KL_DOMAINS] = '{32'hCDEF_89AB, 32'h4C5D_6E7F};

    typedef enum logic [1:0] {
        SEQ_IDLE = 2'd0,
        SEQ_HALF = 2'd1,
        SEQ_OPEN = 2'd2
    } kl_seq_e;

endpackage

// File: rtl/kl_keyseq.sv
// Two-key unlock sequencer for one lock domain.
// Opens after KEY_A then KEY_B with no other access between them; any
// misordered or wrong key sets a sticky fault that blocks reopening
// until reset. Assumes relock and key writes never share a cycle.
module kl_keyseq
    import flash_keylock_pkg::*;
#(
    parameter logic [31:0] KEY_A = 32'h0,
    parameter logic [31:0] KEY_B = 32'h1
) (
    input  logic        clk,
    input  logic        rst_n,
    input  logic        key_wr_i,
    input  logic [31:0] key_i,
    input  logic        gate_i,
    input  logic        abort_i,
    input  logic        relock_i,
    output logic        open_o,
    output logic        err_o
);

    kl_seq_e st_q, st_d;
    logic    hard_q, hard_d;

    // Next-state and error decision for the current key write.
    always_comb begin
        st_d   = st_q;
        hard_d = hard_q;
        err_o  = 1'b0;
        if (key_wr_i) begin
            if (!gate_i || hard_q) begin
                err_o = 1'b1;
            end else begin
                case (st_q)
                    SEQ_IDLE: begin
                        if (key_i == KEY_A) begin
                            st_d = SEQ_HALF;
                        end else begin
                            hard_d = 1'b1;
                            err_o  = 1'b1;
                        end
                    end
                    SEQ_HALF: begin
                        if (key_i == KEY_B) begin
                            st_d = SEQ_OPEN;
                        end else begin
                            st_d   = SEQ_IDLE;
                            hard_d = 1'b1;
                            err_o  = 1'b1;
                        end
                    end
                    default: begin
                        hard_d = 1'b1;
                        err_o  = 1'b1;
                    end
                endcase
            end
        end else if (relock_i) begin
            st_d = SEQ_IDLE;
        end else if (abort_i && st_q == SEQ_HALF) begin
            st_d = SEQ_IDLE;
        end
    end

    // State and sticky fault registers.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            st_q   <= SEQ_IDLE;
            hard_q <= 1'b0;
        end else begin
            st_q   <= st_d;
            hard_q <= hard_d;
        end
    end

    assign open_o = (st_q == SEQ_OPEN);

    // R4: the fault flag never clears outside reset
    p_hard_sticky_r4: assert property (@(posedge clk) disable iff (!rst_n)
        hard_q |=> hard_q);

    // R4: a faulted, closed lock stays closed
    p_hard_blocks_open_r4: assert property (@(posedge clk) disable iff (!rst_n)
        (hard_q && !open_o) |=> !open_o);

    // R2 / R3: opening only follows an accepted second key
    p_open_after_second_key_r2: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(open_o) |-> $past(key_wr_i && gate_i && key_i == KEY_B));

endmodule

// File: rtl/kl_pulser.sv
// Fixed-length pulse generator for the option-reload reset.
// A trigger while a pulse is running is ignored.
module kl_pulser #(
    parameter int unsigned LEN = 4
) (
    input  logic clk,
    input  logic rst_n,
    input  logic fire_i,
    output logic pulse_o
);

    localparam int unsigned CW = $clog2(LEN + 1);

    logic [CW-1:0] cnt_q;

    // Load on trigger, count down while the pulse runs.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            cnt_q <= '0;
        end else if (fire_i && cnt_q == '0) begin
            cnt_q <= CW'(LEN);
        end else if (cnt_q != '0) begin
            cnt_q <= cnt_q - 1'b1;
        end
    end

    assign pulse_o = (cnt_q != '0);

    // R9: the counter never exceeds the pulse length
    p_len_bound_r9: assert property (@(posedge clk) disable iff (!rst_n)
        cnt_q <= CW'(LEN));

endmodule

// File: rtl/kl_regif.sv
// Register front end: decodes accesses, steers key writes to the
// sequencers, applies lock, reload and general-field writes, and
// returns a registered response one cycle after each request.
module kl_regif
    import flash_keylock_pkg::*;
#(
    parameter int unsigned ADDR_W = 4,
    parameter int unsigned CTRL_W = 16
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              req_valid,
    input  logic              req_write,
    input  logic [ADDR_W-1:0] req_addr,
    input  logic [31:0]       req_wdata,
    input  logic              main_open_i,
    input  logic              opt_open_i,
    input  logic              main_err_i,
    input  logic              opt_err_i,
    output logic              main_kw_o,
    output logic              opt_kw_o,
    output logic              main_abort_o,
    output logic              opt_abort_o,
    output logic              main_relock_o,
    output logic              opt_relock_o,
    output logic              reload_fire_o,
    output logic [CTRL_W-1:0] ctrl_o,
    output logic              rsp_valid_o,
    output logic              rsp_err_o,
    output logic [31:0]       rsp_rdata_o
);

    logic              hit_ctrl, hit_mkey, hit_okey, hit_none;
    logic              ctrl_wr, lock_any, gen_upd;
    logic              err_d;
    logic [31:0]       rd_d, ctrl_view;
    logic [CTRL_W-1:0] gen_q;
    logic              unused_wdata;

    assign unused_wdata = ^req_wdata;

    // Address decode and write classification.
    always_comb begin
        hit_ctrl = req_valid && (req_addr == ADDR_W'(KL_ADDR_CTRL));
        hit_mkey = req_valid && (req_addr == ADDR_W'(KL_ADDR_MKEY));
        hit_okey = req_valid && (req_addr == ADDR_W'(KL_ADDR_OKEY));
        hit_none = req_valid && !hit_ctrl && !hit_mkey && !hit_okey;
        ctrl_wr  = hit_ctrl && req_write;
        lock_any = ctrl_wr && (req_wdata[KL_BIT_MLOCK] || req_wdata[KL_BIT_OLOCK]);
        gen_upd  = ctrl_wr && main_open_i && !lock_any;
    end

    assign main_kw_o     = hit_mkey && req_write;
    assign opt_kw_o      = hit_okey && req_write;
    assign main_abort_o  = req_valid && !main_kw_o;
    assign opt_abort_o   = req_valid && !opt_kw_o;
    assign main_relock_o = ctrl_wr && req_wdata[KL_BIT_MLOCK];
    assign opt_relock_o  = ctrl_wr && (req_wdata[KL_BIT_MLOCK] || req_wdata[KL_BIT_OLOCK]);
    assign reload_fire_o = ctrl_wr && main_open_i && opt_open_i && !lock_any
                           && req_wdata[KL_BIT_RELOAD];

    // Control register as seen by a read.
    always_comb begin
        ctrl_view               = '0;
        ctrl_view[KL_BIT_MLOCK] = !main_open_i;
        ctrl_view[KL_BIT_OLOCK] = !opt_open_i;
        ctrl_view[CTRL_W-1:0]   = gen_q;
    end

    // Response data and error selection.
    always_comb begin
        rd_d  = '0;
        err_d = 1'b0;
        if (hit_none) begin
            err_d = 1'b1;
        end else if (main_kw_o) begin
            err_d = main_err_i;
        end else if (opt_kw_o) begin
            err_d = opt_err_i;
        end else if (hit_ctrl && !req_write) begin
            rd_d = ctrl_view;
        end
    end

    // General control field storage.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            gen_q <= '0;
        end else if (gen_upd) begin
            gen_q <= req_wdata[CTRL_W-1:0];
        end
    end

    // Registered response.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            rsp_valid_o <= 1'b0;
            rsp_err_o   <= 1'b0;
            rsp_rdata_o <= '0;
        end else begin
            rsp_valid_o <= req_valid;
            rsp_err_o   <= req_valid && err_d;
            rsp_rdata_o <= req_valid ? rd_d : '0;
        end
    end

    assign ctrl_o = gen_q;

    // R7: control writes while the main lock is closed leave the field alone
    p_locked_discard_r7: assert property (@(posedge clk) disable iff (!rst_n)
        (ctrl_wr && !main_open_i) |=> $stable(gen_q));

    // R10: a lock-bit write never loads the general field
    p_lock_keeps_field_r10: assert property (@(posedge clk) disable iff (!rst_n)
        lock_any |=> $stable(gen_q));

endmodule

// File: rtl/flash_keylock.sv
// Top of the flash control key-lock unit: one register front end, one
// two-key sequencer per lock domain, and the reload pulse generator.
// The option domain only accepts keys while the main domain is open.
module flash_keylock
    import flash_keylock_pkg::*;
#(
    parameter int unsigned ADDR_W     = 4,
    parameter int unsigned CTRL_W     = 16,
    parameter int unsigned RELOAD_LEN = 4
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              req_valid,
    input  logic              req_write,
    input  logic [ADDR_W-1:0] req_addr,
    input  logic [31:0]       req_wdata,
    output logic              rsp_valid,
    output logic              rsp_err,
    output logic [31:0]       rsp_rdata,
    output logic              main_locked,
    output logic              opt_locked,
    output logic [CTRL_W-1:0] ctrl_bits,
    output logic              reload_rst
);

    logic [KL_DOMAINS-1:0] kw, abort, relock, gate, open, err;
    logic                  reload_fire;

    assign gate[0] = 1'b1;
    assign gate[1] = open[0];

    kl_regif #(
        .ADDR_W (ADDR_W),
        .CTRL_W (CTRL_W)
    ) u_regif (
        .clk           (clk),
        .rst_n         (rst_n),
        .req_valid     (req_valid),
        .req_write     (req_write),
        .req_addr      (req_addr),
        .req_wdata     (req_wdata),
        .main_open_i   (open[0]),
        .opt_open_i    (open[1]),
        .main_err_i    (err[0]),
        .opt_err_i     (err[1]),
        .main_kw_o     (kw[0]),
        .opt_kw_o      (kw[1]),
        .main_abort_o  (abort[0]),
        .opt_abort_o   (abort[1]),
        .main_relock_o (relock[0]),
        .opt_relock_o  (relock[1]),
        .reload_fire_o (reload_fire),
        .ctrl_o        (ctrl_bits),
        .rsp_valid_o   (rsp_valid),
        .rsp_err_o     (rsp_err),
        .rsp_rdata_o   (rsp_rdata)
    );

    for (genvar d = 0; d < KL_DOMAINS; d++) begin : g_dom
        kl_keyseq #(
            .KEY_A (KL_KEY_FIRST[d]),
            .KEY_B (KL_KEY_SECOND[d])
        ) u_seq (
            .clk      (clk),
            .rst_n    (rst_n),
            .key_wr_i (kw[d]),
            .key_i    (req_wdata),
            .gate_i   (gate[d]),
            .abort_i  (abort[d]),
            .relock_i (relock[d]),
            .open_o   (open[d]),
            .err_o    (err[d])
        );
    end

    kl_pulser #(
        .LEN (RELOAD_LEN)
    ) u_pulse (
        .clk     (clk),
        .rst_n   (rst_n),
        .fire_i  (reload_fire),
        .pulse_o (reload_rst)
    );

    assign main_locked = !open[0];
    assign opt_locked  = !open[1];

    // R3: the option lock is never open while the main lock is closed
    p_opt_needs_main_r3: assert property (@(posedge clk) disable iff (!rst_n)
        !opt_locked |-> !main_locked);

    // R9: a reload pulse starts only after both locks were open
    p_reload_needs_both_r9: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(reload_rst) |-> $past(!main_locked && !opt_locked));

    // R10: a write carrying a lock bit never starts a reload pulse
    p_lock_beats_reload_r10: assert property (@(posedge clk) disable iff (!rst_n)
        (req_valid && req_write && req_addr == ADDR_W'(KL_ADDR_CTRL)
         && (req_wdata[KL_BIT_MLOCK] || req_wdata[KL_BIT_OLOCK]) && !reload_rst)
        |=> !reload_rst);

endmodule

// File: tb/flash_keylock_bench.sv
// Self-checking bench for the flash control key-lock unit.
module flash_keylock_bench;

    localparam int unsigned ADDR_W = 4;
    localparam int unsigned CTRL_W = 16;
    localparam int unsigned RLEN   = 4;

    localparam logic [31:0] MK1 = 32'h4567_0123;
    localparam logic [31:0] MK2 = 32'hCDEF_89AB;
    localparam logic [31:0] OK1 = 32'h0819_2A3B;
    localparam logic [31:0] OK2 = 32'h4C5D_6E7F;

    logic              clk = 1'b0;
    logic              rst_n = 1'b0;
    logic              req_valid = 1'b0;
    logic              req_write = 1'b0;
    logic [ADDR_W-1:0] req_addr = '0;
    logic [31:0]       req_wdata = '0;
    logic              rsp_valid, rsp_err;
    logic [31:0]       rsp_rdata;
    logic              main_locked, opt_locked, reload_rst;
    logic [CTRL_W-1:0] ctrl_bits;

    int  n_tests = 0;
    int  n_fail  = 0;
    bit  done    = 1'b0;
    logic        e;
    logic [31:0] rd;

    always #5 clk = ~clk;

    flash_keylock #(
        .ADDR_W     (ADDR_W),
        .CTRL_W     (CTRL_W),
        .RELOAD_LEN (RLEN)
    ) u_flash_keylock (
        .clk         (clk),
        .rst_n       (rst_n),
        .req_valid   (req_valid),
        .req_write   (req_write),
        .req_addr    (req_addr),
        .req_wdata   (req_wdata),
        .rsp_valid   (rsp_valid),
        .rsp_err     (rsp_err),
        .rsp_rdata   (rsp_rdata),
        .main_locked (main_locked),
        .opt_locked  (opt_locked),
        .ctrl_bits   (ctrl_bits),
        .reload_rst  (reload_rst)
    );

    task automatic check(input string req, input logic [31:0] act, input logic [31:0] exp);
        n_tests++;
        if (act !== exp) begin
            n_fail++;
            $display("FAIL %s: actual %h expected %h", req, act, exp);
        end
    endtask

    task automatic do_reset();
        @(negedge clk);
        rst_n = 1'b0;
        req_valid = 1'b0;
        repeat (2) @(negedge clk);
        rst_n = 1'b1;
    endtask

    // One access: drive at a falling edge, sample the response one cycle later.
    task automatic acc(input logic wr, input logic [ADDR_W-1:0] a, input logic [31:0] d,
                       output logic err, output logic [31:0] data);
        @(negedge clk);
        req_valid = 1'b1;
        req_write = wr;
        req_addr  = a;
        req_wdata = d;
        @(negedge clk);
        req_valid = 1'b0;
        req_write = 1'b0;
        req_wdata = '0;
        err  = rsp_err;
        data = rsp_rdata;
        if (rsp_valid !== 1'b1) begin
            n_tests++;
            n_fail++;
            $display("FAIL R1: rsp_valid actual %b expected 1", rsp_valid);
        end
    endtask

    task automatic open_main();
        acc(1'b1, 4'd1, MK1, e, rd);
        acc(1'b1, 4'd1, MK2, e, rd);
    endtask

    task automatic open_opt();
        acc(1'b1, 4'd2, OK1, e, rd);
        acc(1'b1, 4'd2, OK2, e, rd);
    endtask

    // Count cycles the reload output stays high, starting now.
    task automatic pulse_len(output int n);
        n = 0;
        while (reload_rst === 1'b1 && n < 20) begin
            n++;
            @(negedge clk);
        end
    endtask

    initial begin
        repeat (100000) @(posedge clk);
        if (!done) begin
            n_tests++;
            n_fail++;
            $display("FAIL watchdog: actual timeout expected completion");
            $display("[TB] %0d tests run, %0d failed", n_tests, n_fail);
            $finish;
        end
    end

    initial begin
        int n;
        do_reset();

        // R1: reset state
        check("R1 main_locked", 32'(main_locked), 32'd1);
        check("R1 opt_locked", 32'(opt_locked), 32'd1);
        check("R1 ctrl_bits", 32'(ctrl_bits), 32'd0);
        check("R1 reload", 32'(reload_rst), 32'd0);
        acc(1'b0, 4'd0, 32'h0, e, rd);
        check("R1 ctrl read", rd, 32'hC000_0000);
        check("R1 ctrl read err", 32'(e), 32'd0);

        // R7: control writes discarded while main lock closed
        acc(1'b1, 4'd0, 32'h0800_FFFF, e, rd);
        check("R7 write err", 32'(e), 32'd0);
        check("R7 ctrl_bits", 32'(ctrl_bits), 32'd0);
        check("R7 no reload", 32'(reload_rst), 32'd0);
        acc(1'b0, 4'd0, 32'h0, e, rd);
        check("R7 readback", rd, 32'hC000_0000);

        // R5: option key while main closed is an error with no effect
        acc(1'b1, 4'd2, OK1, e, rd);
        check("R5 opt key err", 32'(e), 32'd1);
        check("R5 opt still locked", 32'(opt_locked), 32'd1);

        // R2: main unlock sequence
        acc(1'b1, 4'd1, MK1, e, rd);
        check("R2 first key err", 32'(e), 32'd0);
        check("R2 half locked", 32'(main_locked), 32'd1);
        acc(1'b1, 4'd1, MK2, e, rd);
        check("R2 second key err", 32'(e), 32'd0);
        check("R2 main open", 32'(main_locked), 32'd0);
        acc(1'b0, 4'd0, 32'h0, e, rd);
        check("R8 read main open", rd, 32'h4000_0000);

        // R3 + R5: option sequence now works (earlier error left no fault)
        acc(1'b1, 4'd2, OK1, e, rd);
        check("R3 opt first err", 32'(e), 32'd0);
        acc(1'b1, 4'd2, OK2, e, rd);
        check("R3 opt second err", 32'(e), 32'd0);
        check("R5 R3 opt open", 32'(opt_locked), 32'd0);

        // R12: general field sweep over walking ones and patterns
        for (int b = 0; b < CTRL_W; b++) begin
            acc(1'b1, 4'd0, 32'(1) << b, e, rd);
            check("R12 ctrl_bits", 32'(ctrl_bits), 32'(1) << b);
            acc(1'b0, 4'd0, 32'h0, e, rd);
            check("R12 readback", rd, 32'(1) << b);
        end

        // R9: reload pulse with both open
        acc(1'b1, 4'd0, 32'h0800_1234, e, rd);
        pulse_len(n);
        check("R9 pulse length", 32'(n), 32'(RLEN));
        check("R12 field with reload", 32'(ctrl_bits), 32'h1234);
        acc(1'b0, 4'd0, 32'h0, e, rd);
        check("R9 bit27 reads 0", rd, 32'h0000_1234);

        // R10: lock bit and reload in the same write, lock wins
        acc(1'b1, 4'd0, 32'h4800_5678, e, rd);
        pulse_len(n);
        check("R10 no pulse", 32'(n), 32'd0);
        repeat (3) @(negedge clk);
        check("R10 still no pulse", 32'(reload_rst), 32'd0);
        check("R10 opt closed", 32'(opt_locked), 32'd1);
        check("R10 main open", 32'(main_locked), 32'd0);
        check("R10 field kept", 32'(ctrl_bits), 32'h1234);

        // R9: reload ignored with only the main lock open
        acc(1'b1, 4'd0, 32'h0800_1234, e, rd);
        pulse_len(n);
        check("R9 ignored opt closed", 32'(n), 32'd0);

        // R8: option relock then reopen, then main relock closes both
        open_opt();
        check("R8 opt reopened", 32'(opt_locked), 32'd0);
        acc(1'b1, 4'd0, 32'h8000_0000, e, rd);
        check("R8 main closed", 32'(main_locked), 32'd1);
        check("R8 opt closed by main", 32'(opt_locked), 32'd1);
        acc(1'b0, 4'd0, 32'h0, e, rd);
        check("R8 read both closed", rd, 32'hC000_1234);

        // R11: unknown address and key reads
        acc(1'b0, 4'd5, 32'h0, e, rd);
        check("R11 unknown err", 32'(e), 32'd1);
        check("R11 unknown data", rd, 32'h0);
        acc(1'b1, 4'd9, 32'hFFFF_FFFF, e, rd);
        check("R11 unknown write err", 32'(e), 32'd1);
        acc(1'b0, 4'd1, 32'h0, e, rd);
        check("R11 key read err", 32'(e), 32'd0);
        check("R11 key read data", rd, 32'h0);

        // R4: second key first
        do_reset();
        acc(1'b1, 4'd1, MK2, e, rd);
        check("R4 misorder err", 32'(e), 32'd1);
        open_main();
        check("R4 blocked err", 32'(e), 32'd1);
        check("R4 blocked locked", 32'(main_locked), 32'd1);

        // R4: sweep single-bit corruptions of each main key
        for (int b = 0; b < 32; b++) begin
            do_reset();
            acc(1'b1, 4'd1, MK1 ^ (32'(1) << b), e, rd);
            check("R4 bad first key err", 32'(e), 32'd1);
            open_main();
            check("R4 stays locked A", 32'(main_locked), 32'd1);
            do_reset();
            acc(1'b1, 4'd1, MK1, e, rd);
            acc(1'b1, 4'd1, MK2 ^ (32'(1) << b), e, rd);
            check("R4 bad second key err", 32'(e), 32'd1);
            acc(1'b1, 4'd1, MK1, e, rd);
            check("R4 later key err", 32'(e), 32'd1);
            check("R4 stays locked B", 32'(main_locked), 32'd1);
        end

        // R4: key while already open faults; after relock it cannot reopen
        do_reset();
        open_main();
        acc(1'b1, 4'd1, MK1, e, rd);
        check("R4 key while open err", 32'(e), 32'd1);
        check("R4 still open", 32'(main_locked), 32'd0);
        acc(1'b1, 4'd0, 32'h8000_0000, e, rd);
        open_main();
        check("R4 reopen refused", 32'(main_locked), 32'd1);

        // R4: option fault is per domain
        do_reset();
        open_main();
        acc(1'b1, 4'd2, 32'h1111_1111, e, rd);
        check("R4 opt bad key err", 32'(e), 32'd1);
        open_opt();
        check("R4 opt stays locked", 32'(opt_locked), 32'd1);
        check("R4 main unaffected", 32'(main_locked), 32'd0);

        // R6: interrupted sequence
        do_reset();
        acc(1'b1, 4'd1, MK1, e, rd);
        acc(1'b0, 4'd0, 32'h0, e, rd);
        acc(1'b1, 4'd1, MK2, e, rd);
        check("R6 interrupted err", 32'(e), 32'd1);
        check("R6 stays locked", 32'(main_locked), 32'd1);

        // R6: lock-bit write mid-sequence also cancels
        do_reset();
        acc(1'b1, 4'd1, MK1, e, rd);
        acc(1'b1, 4'd0, 32'h8000_0000, e, rd);
        acc(1'b1, 4'd1, MK2, e, rd);
        check("R6 relock mid err", 32'(e), 32'd1);
        check("R6 relock mid locked", 32'(main_locked), 32'd1);

        done = 1'b1;
        $display("[TB] %0d tests run, %0d failed", n_tests, n_fail);
        $finish;
    end

endmodule